// File: doc/BRIEF.md
# Fan PWM Output Conditioner

This block turns an 8-bit fan duty setting into a PWM pin value. A set of override rules sits between the duty setting and the pin. The PWM period is 256 clock enables. The output is high while the period counter is below the effective duty, and a duty of 255 gives a constant high level.

The effective duty is chosen by a fixed priority chain. The top of the chain is pin disable, which tri-states the pin. Next comes a thermal full-speed request, then the forced-on level during an RPM measurement window. At the bottom are two adjustments of the programmed duty: a minimum level, used when the fan depends on its PWM drive for tach pulses and software RPM control is active, and a cut to zero for very small duties in all other cases. A new effective duty is loaded only when a period ends, so no runt pulses appear on the pin.

A small tach counter is included. It synchronises the tach input with two flops and counts its rising edges while the measurement window is open. When the window closes it holds the result. Clearing the tach enable freezes the counter.

Top module: `fan_pwm_cond`

## Requirements
- R1: With no override active, each 256-tick period contains exactly `eff_duty` high ticks. A duty of 0 gives a constant low output and a duty of 255 gives a constant high output.
- R2: A change on `duty_reg` changes `eff_duty` only at a period boundary, which is the tick where the internal counter wraps from 255 to 0.
- R3: A duty below 18 (7 % of full scale, rounded up) becomes 0, except in the mode of R4. A duty of 18 or more passes through unchanged.
- R4: When `tach_mode`=0 and `sw_rpm_mode`=1, a duty below 77 (30 % of full scale, rounded up) is raised to 77. Larger values pass through unchanged.
- R5: When `tach_mode`=0 and `meas_win`=1, the pin is high one clock after the window opens and stays high for as long as the window is open. When `tach_mode`=1, the window has no effect on the pin.
- R6: `therm_ext_low`=1 forces the pin high one clock later, whatever the value of `therm_fan_en`. The effective duty then becomes 255 at the next boundary.
- R7: `therm_int_low`=1 forces the pin high only while `therm_fan_en`=1.
- R8: With `pwm_en`=0, `pwm_oe` is 0 and `pwm_out` is 0, even during a thermal override.
- R9: While `tach_en`=1, rising edges of `tach_in` that occur inside a window are counted. The count appears on `tach_count` one clock after the window closes.
- R10: While `tach_en`=0, `tach_count` holds its value and `tach_in` pulses are ignored.
- R11: After reset, `pwm_out`=0, `eff_duty`=0 and `tach_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_tick | input | 1 | Clock enable that advances the PWM counter |
| duty_reg | input | 8 | Programmed duty |
| sw_rpm_mode | input | 1 | Software RPM control active |
| tach_mode | input | 1 | 1: fan gives tach pulses without PWM drive |
| pwm_en | input | 1 | Pin enable; 0 tri-states the pin |
| tach_en | input | 1 | Tach counter enable |
| therm_fan_en | input | 1 | Allow internal thermal alert to force full speed |
| meas_win | input | 1 | RPM measurement window, active high |
| therm_ext_low | input | 1 | Thermal line pulled low externally |
| therm_int_low | input | 1 | Thermal line driven low internally |
| tach_in | input | 1 | Asynchronous tach pulse input |
| pwm_out | output | 1 | PWM pin value |
| pwm_oe | output | 1 | Pin output enable |
| eff_duty | output | 8 | Effective duty in use for the current period |
| tach_count | output | 16 | Edge count latched at the end of the last window |

## Verification
The bench targets the threshold edges: 17 against 18 for the cut and 10 against 77 for the minimum level. A design with a shifted comparison would let a runt duty through or leave a slow fan stalled. It changes the duty in the middle of a period and expects the old value to hold until the wrap. An early load would show up as a change of `eff_duty` before the boundary. It checks the priority order: pin disable during a thermal request, and an internal alert with its permission cleared. A reordered chain would drive the pin or speed up a fan in silent operation. The tach counter is checked across two windows and one frozen window. A counter that is not cleared or not frozen would report stale or inflated counts.

// File: rtl/fan_pkg.sv
package fan_pkg;

    typedef enum logic [1:0] {
        SRC_REG   = 2'd0,
        SRC_MEAS  = 2'd1,
        SRC_THERM = 2'd2
    } duty_src_e;

    // percentage of full scale, rounded up to the next code
    function automatic int pct_code(input int pct, input int full);
        return (full * pct + 99) / 100;
    endfunction

endpackage

// File: rtl/fan_duty_select.sv
module fan_duty_select
    import fan_pkg::*;
#(
    parameter int DW        = 8,
    parameter int FLOOR_PCT = 30,
    parameter int CUT_PCT   = 7
) (
    input  logic [DW-1:0] duty_reg,
    input  logic          sw_rpm_mode,
    input  logic          tach_mode,
    input  logic          meas_win,
    input  logic          therm_full,
    output logic [DW-1:0] sel_duty,
    output logic          force_on,
    output duty_src_e     src
);
    localparam int FULL = (1 << DW) - 1;
    localparam logic [DW-1:0] FLOOR_CODE = DW'(pct_code(FLOOR_PCT, FULL));
    localparam logic [DW-1:0] CUT_CODE   = DW'(pct_code(CUT_PCT, FULL));

    logic          meas_force;
    logic [DW-1:0] adj_duty;

    always_comb begin
        meas_force = meas_win && !tach_mode;
        if (!tach_mode && sw_rpm_mode) begin
            adj_duty = (duty_reg < FLOOR_CODE) ? FLOOR_CODE : duty_reg;
        end else begin
            adj_duty = (duty_reg < CUT_CODE) ? '0 : duty_reg;
        end

        if (therm_full) begin
            src      = SRC_THERM;
            sel_duty = '1;
        end else if (meas_force) begin
            src      = SRC_MEAS;
            sel_duty = '1;
        end else begin
            src      = SRC_REG;
            sel_duty = adj_duty;
        end
        force_on = therm_full || meas_force;
    end

endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-1:0] sel_duty,
    input  logic          force_on,
    output logic [DW-1:0] duty_q,
    output logic          pwm_q
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] duty;
        logic          pwm;
    } gen_t;

    gen_t st_d, st_q;
    logic wrap;

    always_comb begin
        st_d = st_q;
        wrap = tick && (st_q.cnt == '1);
        if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (wrap) begin
            st_d.duty = sel_duty;
        end
        st_d.pwm = force_on || (st_d.duty == '1) || (st_d.cnt < st_d.duty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign duty_q = st_q.duty;
    assign pwm_q  = st_q.pwm;

    // R2: duty only reloads when the counter wraps
    a_r2_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && st_q.cnt == '1) |=> $stable(duty_q));

    // R5 / R6: a force request reaches the pin on the next clock
    a_r6_force_high: assert property (@(posedge clk) disable iff (!rst_n)
        force_on |=> pwm_q);

endmodule

// File: rtl/fan_tach_count.sv
module fan_tach_count #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tach_in,
    input  logic          tach_en,
    input  logic          meas_win,
    output logic [TW-1:0] count
);
    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          s3;
        logic          win;
        logic [TW-1:0] run;
        logic [TW-1:0] cap;
    } tach_t;

    tach_t st_d, st_q;
    logic  rise;

    always_comb begin
        st_d = st_q;
        rise = st_q.s2 && !st_q.s3;
        if (tach_en) begin
            st_d.s1  = tach_in;
            st_d.s2  = st_q.s1;
            st_d.s3  = st_q.s2;
            st_d.win = meas_win;
            if (meas_win && !st_q.win) begin
                st_d.run = '0;
            end else if (meas_win && rise && (st_q.run != '1)) begin
                st_d.run = st_q.run + 1'b1;
            end
            if (!meas_win && st_q.win) begin
                st_d.cap = st_q.run;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cap;

    // R10: frozen counter keeps its result
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !tach_en |=> $stable(count));

    // R9: window end publishes the running count
    a_r9_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (tach_en && st_q.win && !meas_win) |=> (count == $past(st_q.run)));

endmodule

// File: rtl/fan_pwm_cond.sv
module fan_pwm_cond
    import fan_pkg::*;
#(
    parameter int DW        = 8,
    parameter int TW        = 16,
    parameter int FLOOR_PCT = 30,
    parameter int CUT_PCT   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwm_tick,
    input  logic [DW-1:0] duty_reg,
    input  logic          sw_rpm_mode,
    input  logic          tach_mode,
    input  logic          pwm_en,
    input  logic          tach_en,
    input  logic          therm_fan_en,
    input  logic          meas_win,
    input  logic          therm_ext_low,
    input  logic          therm_int_low,
    input  logic          tach_in,
    output logic          pwm_out,
    output logic          pwm_oe,
    output logic [DW-1:0] eff_duty,
    output logic [TW-1:0] tach_count
);
    localparam int FULL = (1 << DW) - 1;
    localparam logic [DW-1:0] FLOOR_CODE = DW'(pct_code(FLOOR_PCT, FULL));
    localparam logic [DW-1:0] CUT_CODE   = DW'(pct_code(CUT_PCT, FULL));

    logic          therm_full;
    logic [DW-1:0] sel_duty;
    logic          force_on;
    duty_src_e     src;
    logic          pwm_q;

    assign therm_full = therm_ext_low || (therm_int_low && therm_fan_en);

    fan_duty_select #(
        .DW(DW), .FLOOR_PCT(FLOOR_PCT), .CUT_PCT(CUT_PCT)
    ) sel_i (
        .duty_reg   (duty_reg),
        .sw_rpm_mode(sw_rpm_mode),
        .tach_mode  (tach_mode),
        .meas_win   (meas_win),
        .therm_full (therm_full),
        .sel_duty   (sel_duty),
        .force_on   (force_on),
        .src        (src)
    );

    // R3 / R4: a register-sourced duty never lands in the cut band,
    // and never below the minimum in software RPM mode
    a_r3_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_REG) |-> (sel_duty == '0 || sel_duty >= CUT_CODE));
    a_r4_min_level: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_REG && !tach_mode && sw_rpm_mode) |-> (sel_duty >= FLOOR_CODE));

    fan_pwm_gen #(.DW(DW)) gen_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (pwm_tick),
        .sel_duty(sel_duty),
        .force_on(force_on),
        .duty_q  (eff_duty),
        .pwm_q   (pwm_q)
    );

    fan_tach_count #(.TW(TW)) tach_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tach_in (tach_in),
        .tach_en (tach_en),
        .meas_win(meas_win),
        .count   (tach_count)
    );

    assign pwm_oe  = pwm_en;
    assign pwm_out = pwm_en && pwm_q;

    // R8: a disabled pin is never driven high, whatever the override
    a_r8_hiz_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_en |-> (!pwm_out && !pwm_oe));

endmodule

// File: tb/fan_pwm_cond_tb_top.sv
module fan_pwm_cond_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwm_tick = 1'b1;
    logic [7:0]  duty_reg = 8'd0;
    logic        sw_rpm_mode = 1'b0;
    logic        tach_mode = 1'b1;
    logic        pwm_en = 1'b1;
    logic        tach_en = 1'b1;
    logic        therm_fan_en = 1'b1;
    logic        meas_win = 1'b0;
    logic        therm_ext_low = 1'b0;
    logic        therm_int_low = 1'b0;
    logic        tach_in = 1'b0;
    logic        pwm_out, pwm_oe;
    logic [7:0]  eff_duty;
    logic [15:0] tach_count;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fan_pwm_cond dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .duty_reg(duty_reg),
        .sw_rpm_mode(sw_rpm_mode), .tach_mode(tach_mode), .pwm_en(pwm_en),
        .tach_en(tach_en), .therm_fan_en(therm_fan_en), .meas_win(meas_win),
        .therm_ext_low(therm_ext_low), .therm_int_low(therm_int_low),
        .tach_in(tach_in), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
        .eff_duty(eff_duty), .tach_count(tach_count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_eff(input int exp, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (eff_duty == exp[7:0]) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
        end
    endtask

    task automatic duty_case(input string req, input int set, input int exp_eff, input int exp_hi);
        bit ok;
        int h;
        duty_reg = set[7:0];
        wait_eff(exp_eff, ok);
        check({req, " eff_duty reached"}, int'(eff_duty), exp_eff);
        count_high(256, h);
        check({req, " high ticks per period"}, h, exp_hi);
    endtask

    task automatic t_reset;
        check("R11 pwm_out after reset", int'(pwm_out), 0);
        check("R11 eff_duty after reset", int'(eff_duty), 0);
        check("R11 tach_count after reset", int'(tach_count), 0);
    endtask

    task automatic t_basic;  // R1
        tach_mode = 1'b1; sw_rpm_mode = 1'b0;
        duty_case("R1 duty 128", 128, 128, 128);
        duty_case("R1 duty 200", 200, 200, 200);
        duty_case("R1 duty 255", 255, 255, 256);
        duty_case("R1 duty 0", 0, 0, 0);
    endtask

    task automatic t_boundary;  // R2
        bit ok;
        duty_case("R2 setup 100", 100, 100, 100);
        duty_reg = 8'd40;
        wait_eff(100, ok);
        cyc(120);
        check("R2 eff held mid period", int'(eff_duty), 100);
        wait_eff(40, ok);
        check("R2 eff loaded at boundary", int'(eff_duty), 40);
    endtask

    task automatic t_cut;  // R3
        tach_mode = 1'b1; sw_rpm_mode = 1'b0;
        duty_case("R3 duty 17 cut", 17, 0, 0);
        duty_case("R3 duty 18 kept", 18, 18, 18);
        tach_mode = 1'b0;
        duty_case("R3 duty 5 cut tach_mode0", 5, 0, 0);
        tach_mode = 1'b1; sw_rpm_mode = 1'b1;
        duty_case("R3 duty 10 cut tach_mode1 swrpm", 10, 0, 0);
        sw_rpm_mode = 1'b0;
    endtask

    task automatic t_floor;  // R4
        tach_mode = 1'b0; sw_rpm_mode = 1'b1;
        duty_case("R4 duty 10 raised", 10, 77, 77);
        duty_case("R4 duty 150 kept", 150, 150, 150);
        sw_rpm_mode = 1'b0; tach_mode = 1'b1;
        duty_case("R4 back to 0", 0, 0, 0);
    endtask

    task automatic t_meas;  // R5
        int h;
        tach_mode = 1'b0;
        meas_win = 1'b1;
        cyc(1);
        count_high(300, h);
        check("R5 forced high in window", h, 300);
        meas_win = 1'b0;
        tach_mode = 1'b1;
        duty_case("R5 settle", 0, 0, 0);
        meas_win = 1'b1;
        count_high(300, h);
        check("R5 tach_mode1 window no effect", h, 0);
        meas_win = 1'b0;
    endtask

    task automatic t_therm;  // R6 R7
        int h;
        bit ok;
        therm_fan_en = 1'b0;
        therm_ext_low = 1'b1;
        cyc(1);
        count_high(300, h);
        check("R6 external alert full speed", h, 300);
        wait_eff(255, ok);
        check("R6 eff_duty full", int'(eff_duty), 255);
        therm_ext_low = 1'b0;
        duty_case("R6 release", 0, 0, 0);
        therm_int_low = 1'b1;
        cyc(1);
        count_high(300, h);
        check("R7 internal alert blocked", h, 0);
        therm_fan_en = 1'b1;
        cyc(1);
        count_high(300, h);
        check("R7 internal alert allowed", h, 300);
        therm_int_low = 1'b0;
    endtask

    task automatic t_hiz;  // R8
        int h;
        pwm_en = 1'b0;
        therm_ext_low = 1'b1;
        cyc(2);
        check("R8 oe low", int'(pwm_oe), 0);
        count_high(300, h);
        check("R8 out low while disabled", h, 0);
        therm_ext_low = 1'b0;
        pwm_en = 1'b1;
        cyc(2);
        check("R8 oe back", int'(pwm_oe), 1);
    endtask

    task automatic tach_window(input int pulses);
        meas_win = 1'b1;
        cyc(3);
        for (int i = 0; i < pulses; i++) begin
            tach_in = 1'b1; cyc(4);
            tach_in = 1'b0; cyc(4);
        end
        cyc(4);
        meas_win = 1'b0;
        cyc(3);
    endtask

    task automatic t_tach;  // R9 R10
        tach_mode = 1'b1;
        tach_window(5);
        check("R9 first window count", int'(tach_count), 5);
        tach_window(3);
        check("R9 second window count", int'(tach_count), 3);
        tach_en = 1'b0;
        tach_window(7);
        check("R10 frozen count", int'(tach_count), 3);
        tach_en = 1'b1;
        cyc(4);
        check("R10 still held after re-enable", int'(tach_count), 3);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_basic();
        t_boundary();
        t_cut();
        t_floor();
        t_meas();
        t_therm();
        t_hiz();
        t_tach();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule